// File: doc/BRIEF.md
# Bit-Masked GPIO Port

This block is an eight-pin general-purpose I/O port reached over a plain register bus. The bus has an address, write data, a write strobe and read data. The pin value register has no single address. It occupies a whole window, and the word-address bits inside that window choose the pins an access touches. Software can therefore set, clear or sample any subset of pins in one bus cycle, with no read-modify-write sequence and no locking between the agents that share the port.

A direction register picks, for each pin, whether the port drives it. The port presents output-enable and output-value buses to the pads. Pad levels enter through a two-flop synchronizer before any read can see them. A fixed identification value can be read back one byte at a time. Read data is registered. It reflects the state the port held before any write made in the same cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted and right after it, the direction register and the output register are 0. `pad_oe`, `pad_out` and `bus_rdata` all read 0.
- R2: A write to the data window (address below 0x400, low two address bits 0) changes output bit n only if address bit n+2 is 1. All other output bits keep their value.
- R3: A data write to a pin whose direction bit is 0 leaves that pin's output value unchanged. The value takes effect only when it is written again after the direction bit has been set to 1.
- R4: A data-window read returns 0 in every bit n whose address bit n+2 is 0.
- R5: In a data read, a masked bit returns the driven output value if the pin's direction bit is 1, and the synchronized pad level if the bit is 0. A pad change applied just before clock edge k reaches read data no earlier than edge k+2.
- R6: The direction register sits at address 0x400 and reads back as written. Bit n = 1 drives pin n, and `pad_oe` equals the register.
- R7: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the identification bytes 0x61, 0x10, 0x04 and 0x00, least significant byte first. Their low 20 bits form 0x41061.
- R8: Any other address reads 0 and ignores writes. This includes any address with nonzero low two bits.
- R9: `bus_rdata` is updated on the clock edge after the address is presented. In a write cycle it returns the register state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_in | input | 8 | Asynchronous pad levels |

## Verification
A write and a read of the same register fall in one cycle whenever the write strobe is high, because every cycle's address also produces read data. The scoreboard predicts the pre-write value for such cycles, using data writes, direction writes and masked writes. A pad change can also meet a data read in the same cycle. The bench changes `pad_in` on the very cycle a read is issued and expects the old level. It then expects the new level two cycles later.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    typedef enum logic [1:0] {
        RG_DATA  = 2'd0,
        RG_DIR   = 2'd1,
        RG_IDENT = 2'd2,
        RG_NONE  = 2'd3
    } region_e;

    localparam logic [11:0] DIR_OFS   = 12'h400;
    localparam logic [11:0] IDENT_OFS = 12'hFE0;
    localparam int          IDENT_SLOTS = 4;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_mask_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_PINS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output region_e             region,
    output logic [NUM_PINS-1:0] pin_mask,
    output logic [1:0]          ident_sel
);
    localparam int WIN_W = NUM_PINS + 2;

    logic aligned;
    logic in_window;
    logic is_dir;
    logic is_ident;

    assign aligned   = (addr[1:0] == 2'b00);
    assign in_window = ((addr >> WIN_W) == '0);
    assign is_dir    = (addr == ADDR_W'(DIR_OFS));
    assign is_ident  = ((addr >> 4) == (ADDR_W'(IDENT_OFS) >> 4));

    always_comb begin
        if (!aligned)       region = RG_NONE;
        else if (in_window) region = RG_DATA;
        else if (is_dir)    region = RG_DIR;
        else if (is_ident)  region = RG_IDENT;
        else                region = RG_NONE;
    end

    assign pin_mask  = addr[WIN_W-1:2];
    assign ident_sel = addr[3:2];
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_mask_pkg::*;
#(
    parameter int          NUM_PINS = 8,
    parameter logic [31:0] ID_VALUE = 32'h0004_1061
) (
    input  region_e             region,
    input  logic [NUM_PINS-1:0] pin_mask,
    input  logic [NUM_PINS-1:0] dir,
    input  logic [NUM_PINS-1:0] out_val,
    input  logic [NUM_PINS-1:0] pad_sync,
    input  logic [1:0]          ident_sel,
    output logic [NUM_PINS-1:0] rdata
);
    logic [NUM_PINS-1:0] live;
    logic [7:0]          ident_byte;

    assign live       = (dir & out_val) | (~dir & pad_sync);
    assign ident_byte = ID_VALUE[{ident_sel, 3'b000} +: 8];

    always_comb begin
        case (region)
            RG_DATA:  rdata = live & pin_mask;
            RG_DIR:   rdata = dir;
            RG_IDENT: rdata = NUM_PINS'(ident_byte);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int          NUM_PINS    = 8,
    parameter int          ADDR_W      = 12,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] ID_VALUE    = 32'h0004_1061
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    input  logic                bus_we,
    output logic [NUM_PINS-1:0] bus_rdata,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    input  logic [NUM_PINS-1:0] pad_in
);
    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out_val;
        logic [NUM_PINS-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    region_e             region;
    logic [NUM_PINS-1:0] pin_mask;
    logic [1:0]          ident_sel;
    logic [NUM_PINS-1:0] pad_sync;
    logic [NUM_PINS-1:0] rd_val;
    logic [NUM_PINS-1:0] wr_en;

    gpio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_PINS (NUM_PINS)
    ) u_dec (
        .addr      (bus_addr),
        .region    (region),
        .pin_mask  (pin_mask),
        .ident_sel (ident_sel)
    );

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    gpio_read_mux #(
        .NUM_PINS (NUM_PINS),
        .ID_VALUE (ID_VALUE)
    ) u_rmux (
        .region    (region),
        .pin_mask  (pin_mask),
        .dir       (st_q.dir),
        .out_val   (st_q.out_val),
        .pad_sync  (pad_sync),
        .ident_sel (ident_sel),
        .rdata     (rd_val)
    );

    // Only pins that are both addressed and configured as outputs accept data.
    assign wr_en = pin_mask & st_q.dir;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_val;
        if (bus_we) begin
            case (region)
                RG_DATA: st_d.out_val = (st_q.out_val & ~wr_en) | (bus_wdata & wr_en);
                RG_DIR:  st_d.dir     = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pad_oe    = st_q.dir;
    assign pad_out   = st_q.out_val;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out
);
    localparam int WIN_W = NUM_PINS + 2;

    logic                data_hit;
    logic                dir_hit;
    logic                ident_hit;
    logic                unimpl;
    logic [NUM_PINS-1:0] mask;

    assign data_hit  = (bus_addr[1:0] == 2'b00) && ((bus_addr >> WIN_W) == '0);
    assign dir_hit   = (bus_addr == ADDR_W'(12'h400));
    assign ident_hit = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == (ADDR_W'(12'hFE0) >> 4));
    assign unimpl    = !data_hit && !dir_hit && !ident_hit;
    assign mask      = bus_addr[WIN_W-1:2];

    // R2: outside a data write the driven values do not move
    a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && data_hit) |=> $stable(pad_out));

    // R2: a data write only touches addressed pins
    a_r2_masked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && data_hit) |=> ((pad_out ^ $past(pad_out)) & ~$past(mask)) == '0);

    // R3: pins configured as inputs keep their output value
    a_r3_input_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && data_hit) |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0);

    // R4: unaddressed pins read as zero
    a_r4_unmasked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        data_hit |=> (bus_rdata & ~$past(mask)) == '0);

    // R6: direction only changes by a write to its address
    a_r6_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && dir_hit) |=> $stable(pad_oe));

    // R8: unimplemented addresses read zero
    a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |=> bus_rdata == '0);
endmodule

bind gpio_mask_port gpio_mask_port_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/sim_gpio_mask_port.sv
module sim_gpio_mask_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_oe;
    logic [7:0]  pad_out;
    logic [7:0]  pad_in = '0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       chk_req = 1'b0;
    logic       req_d = 1'b0;

    always #5 clk = ~clk;

    gpio_mask_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_in    (pad_in)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Driver: present one bus cycle at the current negedge, queue the expected read data.
    task automatic issue(input logic [11:0] a, input logic [7:0] wd, input logic we,
                         input logic [7:0] exp, input string tag);
        bus_addr  = a;
        bus_wdata = wd;
        bus_we    = we;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        chk_req = 1'b1;
        @(negedge clk);
        bus_we  = 1'b0;
        chk_req = 1'b0;
    endtask

    task automatic xfer(input logic [11:0] a, input logic [7:0] wd, input logic we,
                        input logic [7:0] exp, input string tag);
        @(negedge clk);
        issue(a, wd, we, exp, tag);
    endtask

    // Monitor: the read data for a cycle is registered at the next posedge.
    always @(posedge clk) req_d <= chk_req;

    always @(negedge clk) begin
        if (req_d) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL scoreboard underflow actual=%02h expected=none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, bus_rdata, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pad_oe in reset", pad_oe, 8'h00);
        check("R1 pad_out in reset", pad_out, 8'h00);
        check("R1 rdata in reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pad_oe after reset", pad_oe, 8'h00);

        xfer(12'h400, 8'h00, 1'b0, 8'h00, "R6 dir reset readback");
        xfer(12'h3FC, 8'hFF, 1'b1, 8'h00, "R9 read during data write");
        check("R3 write to input pins dropped", pad_out, 8'h00);
        xfer(12'h400, 8'h0F, 1'b1, 8'h00, "R9 dir old value during write");
        check("R6 pad_oe follows dir", pad_oe, 8'h0F);
        xfer(12'h400, 8'h00, 1'b0, 8'h0F, "R6 dir readback");
        xfer(12'h3FC, 8'hA5, 1'b1, 8'h00, "R9 data old value during write");
        check("R2 R3 only output pins take data", pad_out, 8'h05);
        xfer(12'h008, 8'hFF, 1'b1, 8'h00, "R4 single pin1 before write");
        check("R2 single pin set", pad_out, 8'h07);
        xfer(12'h004, 8'h00, 1'b1, 8'h01, "R4 single pin0 before write");
        check("R2 single pin clear", pad_out, 8'h06);

        pad_in = 8'hC0;
        repeat (3) @(negedge clk);
        xfer(12'h3FC, 8'h00, 1'b0, 8'hC6, "R5 mixed in/out read");
        xfer(12'h300, 8'h00, 1'b0, 8'hC0, "R4 mask pins 6-7");
        xfer(12'h00C, 8'h00, 1'b0, 8'h02, "R4 mask pins 0-1");

        // Pad change in the same cycle as a read: old level first, new level two cycles on.
        @(negedge clk);
        pad_in = 8'h30;
        issue(12'h3FC, 8'h00, 1'b0, 8'hC6, "R5 sync latency old level");
        xfer(12'h3FC, 8'h00, 1'b0, 8'h36, "R5 sync latency new level");

        xfer(12'h200, 8'h80, 1'b1, 8'h00, "R4 pin7 before input write");
        check("R3 input pin7 write dropped", pad_out, 8'h06);
        xfer(12'h400, 8'hFF, 1'b1, 8'h0F, "R9 dir old value");
        check("R3 dir change keeps old value", pad_out, 8'h06);
        xfer(12'h200, 8'h80, 1'b1, 8'h00, "R5 pin7 output reads driven value");
        check("R3 rewrite after dir takes effect", pad_out, 8'h86);

        xfer(12'hFE0, 8'h00, 1'b0, 8'h61, "R7 ident byte 0");
        xfer(12'hFE4, 8'h00, 1'b0, 8'h10, "R7 ident byte 1");
        xfer(12'hFE8, 8'h00, 1'b0, 8'h04, "R7 ident byte 2");
        xfer(12'hFEC, 8'h00, 1'b0, 8'h00, "R7 ident byte 3");

        xfer(12'h500, 8'h00, 1'b1, 8'h00, "R8 unimplemented read");
        xfer(12'h400, 8'h00, 1'b0, 8'hFF, "R8 dir untouched by stray write");
        check("R8 pad_out untouched", pad_out, 8'h86);
        xfer(12'h3FE, 8'h00, 1'b1, 8'h00, "R8 misaligned reads zero");
        check("R8 misaligned write ignored", pad_out, 8'h86);
        xfer(12'hFF0, 8'h00, 1'b0, 8'h00, "R8 beyond ident reads zero");

        xfer(12'h3FC, 8'h0F, 1'b1, 8'h86, "R9 full read during full write");
        check("R2 full write", pad_out, 8'h0F);

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", 8'(exp_q.size()), 8'h00);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule